// File: doc/BRIEF.md
# Mailbox User Interrupt Status Unit

This block collects the interrupt events of one mailbox user. Every mailbox in the group produces two single-cycle event pulses. The first says a new message has arrived. The second says the message queue has room again. The block latches each pulse into a raw status bit and holds a per-bit enable mask. A masked status view is the AND of raw status and enable. The block drives one interrupt line for the user, high whenever any masked bit is set.

Software reaches the block through a simple command port. Each cycle it may issue one command with a write value. The commands are:

- read raw status
- read masked status
- read the enable mask
- write-one-to-clear status
- write-one-to-set enable
- write-one-to-clear enable

Read data comes back one cycle later with a valid strobe. The message queues themselves sit outside this block. The number of mailboxes is set by a parameter.

Top module: `mbx_irq_unit`

## Requirements
- R1: For mailbox m, status bit 2m records the new-message pulse and bit 2m+1 records the queue-not-full pulse; the same bit positions apply to the enable mask and to every read.
- R2: A pulse sets its raw status bit on the next clock edge whatever the value of its enable bit, and the bit stays set until cleared.
- R3: Command code 4 (clear status) clears every raw status bit whose write-data bit is 1, which also removes it from the masked view; write-data bits of 0 leave their status bits unchanged.
- R4: Command code 5 (set enable) sets every enable bit whose write-data bit is 1; zero bits leave enables unchanged, and no other command alters the enable mask.
- R5: Command code 6 (clear enable) clears every enable bit whose write-data bit is 1; zero bits leave enables unchanged; a masked event still appears in raw status but not in the masked view or on the interrupt.
- R6: Command code 2 returns the masked status, equal to raw status AND enable.
- R7: The single interrupt output is high exactly when at least one masked status bit is 1.
- R8: When a pulse and a clear-status command hit the same bit in the same cycle, the bit ends up set.
- R9: Command code 3 returns the current enable mask, and command code 1 returns the raw status.
- R10: After synchronous reset all raw status and enable bits are 0 and the interrupt is low.
- R11: A read command (codes 1 to 3) presented with cmd_valid at a clock edge makes rd_valid high for exactly the following cycle, with rd_data holding the register value from just before that edge; codes 0 and 7 and the write commands do not raise rd_valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_newmsg | input | N_MBX | Per-mailbox new-message pulse |
| evt_notfull | input | N_MBX | Per-mailbox queue-not-full pulse |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command code (1 raw read, 2 masked read, 3 enable read, 4 clear status, 5 set enable, 6 clear enable) |
| cmd_wdata | input | 2*N_MBX | Write bit mask for write commands |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 2*N_MBX | Read data |
| irq | output | 1 | User interrupt |

## Verification
The assertions check several rules on every cycle. Each pulse is captured into raw status, including when a clear hits the same bit. Clear and set commands have the stated effect on their bits. The enable mask stays unchanged under every other command. The read strobe follows exactly the read commands. The interrupt always equals the OR of raw status AND enable.

Some properties can only be shown by the bench's scenarios. These are the interleaved bit mapping of the two event kinds, and the exact value a read returns when an event lands in the same cycle. They also include the values seen after reset, and the fact that zero write bits and masked events leave the visible state untouched.

// File: rtl/mbx_irq_pkg.sv
package mbx_irq_pkg;

    typedef enum logic [2:0] {
        CMD_IDLE   = 3'd0,
        CMD_RD_RAW = 3'd1,
        CMD_RD_MSK = 3'd2,
        CMD_RD_EN  = 3'd3,
        CMD_CLR_ST = 3'd4,
        CMD_SET_EN = 3'd5,
        CMD_CLR_EN = 3'd6,
        CMD_RSVD   = 3'd7
    } mbx_cmd_e;

    typedef enum logic [1:0] {
        SEL_RAW = 2'd0,
        SEL_MSK = 2'd1,
        SEL_EN  = 2'd2
    } mbx_sel_e;

    typedef struct packed {
        logic     clr_st;
        logic     set_en;
        logic     clr_en;
        logic     rd;
        mbx_sel_e sel;
    } mbx_dec_t;

    function automatic mbx_dec_t mbx_decode(input logic valid, input logic [2:0] op);
        mbx_dec_t d;
        d = '{clr_st: 1'b0, set_en: 1'b0, clr_en: 1'b0, rd: 1'b0, sel: SEL_RAW};
        if (valid) begin
            case (op)
                CMD_RD_RAW: begin d.rd = 1'b1; d.sel = SEL_RAW; end
                CMD_RD_MSK: begin d.rd = 1'b1; d.sel = SEL_MSK; end
                CMD_RD_EN:  begin d.rd = 1'b1; d.sel = SEL_EN;  end
                CMD_CLR_ST: d.clr_st = 1'b1;
                CMD_SET_EN: d.set_en = 1'b1;
                CMD_CLR_EN: d.clr_en = 1'b1;
                default: ;
            endcase
        end
        return d;
    endfunction

endpackage

// File: rtl/mbx_irq_evt_map.sv
module mbx_irq_evt_map #(
    parameter int N_MBX = 4,
    localparam int W = 2 * N_MBX
) (
    input  logic [N_MBX-1:0] newmsg,
    input  logic [N_MBX-1:0] notfull,
    output logic [W-1:0]     evt_vec
);
    for (genvar m = 0; m < N_MBX; m++) begin : g_mbx
        assign evt_vec[2*m]   = newmsg[m];
        assign evt_vec[2*m+1] = notfull[m];
    end
endmodule

// File: rtl/mbx_irq_status.sv
module mbx_irq_status #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] evt_vec,
    input  logic         clr_req,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] raw_q
);
    logic [W-1:0] kill;
    logic [W-1:0] raw_d;

    always_comb begin
        kill  = clr_req ? clr_mask : '0;
        // events are ORed in after the clear so a same-cycle pulse wins
        raw_d = (raw_q & ~kill) | evt_vec;
    end

    always_ff @(posedge clk) begin
        if (rst) raw_q <= '0;
        else     raw_q <= raw_d;
    end
endmodule

// File: rtl/mbx_irq_enable.sv
module mbx_irq_enable #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         set_req,
    input  logic         clr_req,
    input  logic [W-1:0] mask,
    output logic [W-1:0] en_q
);
    logic [W-1:0] en_d;

    always_comb begin
        en_d = en_q;
        if (set_req) en_d = en_q | mask;
        if (clr_req) en_d = en_q & ~mask;
    end

    always_ff @(posedge clk) begin
        if (rst) en_q <= '0;
        else     en_q <= en_d;
    end
endmodule

// File: rtl/mbx_irq_rdport.sv
module mbx_irq_rdport
    import mbx_irq_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         rd_req,
    input  mbx_sel_e     sel,
    input  logic [W-1:0] raw,
    input  logic [W-1:0] masked,
    input  logic [W-1:0] en,
    output logic         rd_valid,
    output logic [W-1:0] rd_data
);
    logic [W-1:0] pick;

    always_comb begin
        case (sel)
            SEL_MSK: pick = masked;
            SEL_EN:  pick = en;
            default: pick = raw;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_req;
            if (rd_req) rd_data <= pick;
        end
    end
endmodule

// File: rtl/mbx_irq_unit.sv
module mbx_irq_unit
    import mbx_irq_pkg::*;
#(
    parameter int N_MBX = 4,
    localparam int W = 2 * N_MBX
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_MBX-1:0] evt_newmsg,
    input  logic [N_MBX-1:0] evt_notfull,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [W-1:0]     cmd_wdata,
    output logic             rd_valid,
    output logic [W-1:0]     rd_data,
    output logic             irq
);
    mbx_dec_t     dec;
    logic [W-1:0] evt_vec;
    logic [W-1:0] raw_q;
    logic [W-1:0] en_q;
    logic [W-1:0] masked;

    assign dec = mbx_decode(cmd_valid, cmd_op);

    mbx_irq_evt_map #(.N_MBX(N_MBX)) u_map (
        .newmsg  (evt_newmsg),
        .notfull (evt_notfull),
        .evt_vec (evt_vec)
    );

    mbx_irq_status #(.W(W)) u_status (
        .clk      (clk),
        .rst      (rst),
        .evt_vec  (evt_vec),
        .clr_req  (dec.clr_st),
        .clr_mask (cmd_wdata),
        .raw_q    (raw_q)
    );

    mbx_irq_enable #(.W(W)) u_enable (
        .clk     (clk),
        .rst     (rst),
        .set_req (dec.set_en),
        .clr_req (dec.clr_en),
        .mask    (cmd_wdata),
        .en_q    (en_q)
    );

    assign masked = raw_q & en_q;
    assign irq    = |masked;

    mbx_irq_rdport #(.W(W)) u_rd (
        .clk      (clk),
        .rst      (rst),
        .rd_req   (dec.rd),
        .sel      (dec.sel),
        .raw      (raw_q),
        .masked   (masked),
        .en       (en_q),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );
endmodule

// File: rtl/mbx_irq_unit_chk.sv
module mbx_irq_unit_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         cmd_valid,
    input logic [2:0]   cmd_op,
    input logic [W-1:0] cmd_wdata,
    input logic [W-1:0] evt_vec,
    input logic [W-1:0] raw_q,
    input logic [W-1:0] en_q,
    input logic         rd_valid,
    input logic         irq
);
    logic is_rd, is_clr_st, is_set_en, is_clr_en;
    assign is_rd     = cmd_valid && (cmd_op == 3'd1 || cmd_op == 3'd2 || cmd_op == 3'd3);
    assign is_clr_st = cmd_valid && cmd_op == 3'd4;
    assign is_set_en = cmd_valid && cmd_op == 3'd5;
    assign is_clr_en = cmd_valid && cmd_op == 3'd6;

    AST_EVT_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (evt_vec != '0) |=> ((raw_q & $past(evt_vec)) == $past(evt_vec))); // R8

    AST_CLR_STATUS: assert property (@(posedge clk) disable iff (rst)
        is_clr_st |=> ((raw_q & $past(cmd_wdata) & ~$past(evt_vec)) == '0)); // R3

    AST_CLR_KEEPS: assert property (@(posedge clk) disable iff (rst)
        is_clr_st |=> ((raw_q & ~$past(cmd_wdata)) == ($past(raw_q) & ~$past(cmd_wdata)) | ($past(evt_vec) & ~$past(cmd_wdata)))); // R3

    AST_SET_EN: assert property (@(posedge clk) disable iff (rst)
        is_set_en |=> ((en_q & $past(cmd_wdata)) == $past(cmd_wdata))); // R4

    AST_CLR_EN: assert property (@(posedge clk) disable iff (rst)
        is_clr_en |=> ((en_q & $past(cmd_wdata)) == '0)); // R5

    AST_EN_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(is_set_en || is_clr_en) |=> $stable(en_q)); // R4

    AST_RD_STROBE: assert property (@(posedge clk) disable iff (rst)
        is_rd |=> rd_valid); // R11

    AST_RD_QUIET: assert property (@(posedge clk) disable iff (rst)
        !is_rd |=> !rd_valid); // R11

    AST_IRQ_OR: assert property (@(posedge clk) disable iff (rst)
        irq == ((raw_q & en_q) != '0)); // R7
endmodule

bind mbx_irq_unit mbx_irq_unit_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_wdata (cmd_wdata),
    .evt_vec   (evt_vec),
    .raw_q     (raw_q),
    .en_q      (en_q),
    .rd_valid  (rd_valid),
    .irq       (irq)
);

// File: tb/tb_mbx_irq_unit.sv
module tb_mbx_irq_unit;
    localparam int N = 4;
    localparam int W = 2 * N;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] evt_newmsg = '0;
    logic [N-1:0] evt_notfull = '0;
    logic         cmd_valid = 1'b0;
    logic [2:0]   cmd_op = 3'd0;
    logic [W-1:0] cmd_wdata = '0;
    logic         rd_valid;
    logic [W-1:0] rd_data;
    logic         irq;

    always #10 clk = ~clk;

    mbx_irq_unit #(.N_MBX(N)) dut (
        .clk(clk), .rst(rst),
        .evt_newmsg(evt_newmsg), .evt_notfull(evt_notfull),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_wdata(cmd_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .irq(irq)
    );

    typedef struct {
        logic [W-1:0] data;
        string        tag;
    } exp_t;

    exp_t         sb[$];
    int           total = 0;
    int           bad = 0;
    logic [W-1:0] m_raw = '0;
    logic [W-1:0] m_en = '0;
    string        irq_tag = "R7";
    bit           mon_on = 1'b0;

    function automatic logic [W-1:0] evmap(logic [N-1:0] nm, logic [N-1:0] nf);
        logic [W-1:0] v;
        for (int m = 0; m < N; m++) begin
            v[2*m]   = nm[m];
            v[2*m+1] = nf[m];
        end
        return v;
    endfunction

    task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one command cycle; called just after a falling edge
    task automatic step(logic [2:0] op, logic [W-1:0] wd, logic [N-1:0] nm,
                        logic [N-1:0] nf, string tag);
        logic [W-1:0] ev;
        exp_t e;
        ev = evmap(nm, nf);
        cmd_valid = (op != 3'd0);
        cmd_op = op; cmd_wdata = wd; evt_newmsg = nm; evt_notfull = nf;
        if (op >= 3'd1 && op <= 3'd3) begin
            e.tag = tag;
            e.data = (op == 3'd1) ? m_raw : (op == 3'd2) ? (m_raw & m_en) : m_en;
            sb.push_back(e);
        end
        @(posedge clk);
        if (op == 3'd4) m_raw = m_raw & ~wd;
        m_raw = m_raw | ev;
        if (op == 3'd5) m_en = m_en | wd;
        if (op == 3'd6) m_en = m_en & ~wd;
        irq_tag = tag;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd0; cmd_wdata = '0;
        evt_newmsg = '0; evt_notfull = '0;
    endtask

    // monitor: pops the scoreboard on read strobes, checks irq every cycle
    always @(negedge clk) begin
        if (mon_on) begin
            check({irq_tag, " irq"}, {{(W-1){1'b0}}, irq},
                  {{(W-1){1'b0}}, ((m_raw & m_en) != '0)});
            if (rd_valid) begin
                if (sb.size() == 0) check("R11 unexpected read", {{(W-1){1'b0}}, 1'b1}, '0);
                else begin
                    exp_t e;
                    e = sb.pop_front();
                    check({e.tag, " read"}, rd_data, e.data);
                end
            end
        end
    end

    initial begin
        #1000000;
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        mon_on = 1'b1;
        // R10 reset values
        step(3'd1, '0, '0, '0, "R10");
        step(3'd2, '0, '0, '0, "R10");
        step(3'd3, '0, '0, '0, "R10");
        // R1 R2 new message on mailbox 1 with enables off -> bit 2
        step(3'd0, '0, 4'b0010, '0, "R2");
        step(3'd1, '0, '0, '0, "R1");
        step(3'd2, '0, '0, '0, "R2");
        // R1 queue-not-full on mailbox 2 -> bit 5
        step(3'd0, '0, '0, 4'b0100, "R1");
        step(3'd1, '0, '0, '0, "R1");
        // R4 R7 enable bit 2 -> interrupt
        step(3'd5, 8'h04, '0, '0, "R4");
        step(3'd3, '0, '0, '0, "R9");
        step(3'd2, '0, '0, '0, "R6");
        step(3'd5, 8'h00, '0, '0, "R4");
        step(3'd3, '0, '0, '0, "R4");
        // R3 zero write, then clear bit 2
        step(3'd4, 8'h00, '0, '0, "R3");
        step(3'd1, '0, '0, '0, "R3");
        step(3'd4, 8'h04, '0, '0, "R3");
        step(3'd1, '0, '0, '0, "R3");
        step(3'd2, '0, '0, '0, "R3");
        // R8 pulse and clear same bit same cycle
        step(3'd5, 8'h01, '0, '0, "R8");
        step(3'd4, 8'h01, 4'b0001, '0, "R8");
        step(3'd1, '0, '0, '0, "R8");
        // R5 zero clear-enable write, then mask bit 0
        step(3'd6, 8'h00, '0, '0, "R5");
        step(3'd3, '0, '0, '0, "R5");
        step(3'd6, 8'h01, '0, '0, "R5");
        step(3'd4, 8'hFF, '0, '0, "R5");
        step(3'd0, '0, 4'b0001, '0, "R5");
        step(3'd1, '0, '0, '0, "R5");
        step(3'd2, '0, '0, '0, "R5");
        // R11 read with event in same cycle returns pre-edge value
        step(3'd1, '0, 4'b1000, 4'b1000, "R11");
        step(3'd1, '0, '0, '0, "R11");
        // R7 several enables, all mailboxes
        step(3'd5, 8'hA0, '0, '0, "R7");
        step(3'd0, '0, '0, 4'b1111, "R7");
        step(3'd2, '0, '0, '0, "R6");
        step(3'd4, 8'hFF, '0, '0, "R7");
        step(3'd7, 8'hFF, '0, '0, "R11");
        step(3'd3, '0, '0, '0, "R9");
        repeat (2) @(negedge clk);
        check("R11 scoreboard empty", sb.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule